// File: doc/BRIEF.md
# Extended-Operand Integer Execution Unit

This block is the integer execution stage of a CISC-style core. Each issued operation carries more than an opcode and two operands. It also names a source width and a destination width. It picks sign or zero widening for the source. It carries one bit that inverts the operation's normal flag behaviour. It may also carry a predicate on the current flags. A single operation therefore does the work of a widen, an arithmetic step, a flag fix-up and a conditional branch around it.

Operand `a` is the first source at destination width. Operand `b` is the second source, or the only source of a unary operation. Operand `b` is read at the source width and widened to the destination width. The unit computes the result and the five flags. It then decides whether the result and the flags are committed. All outputs are registered and appear one clock after the operation is presented. The register-file merge and all memory handling stay outside the block.

Top module: `ext_int_exec`

## Requirements
- R1: Size codes are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 bitwise NOT, 4 move, 5 population count, 6 compare-to-mask and 7 compare-to-boolean. All result bits above the destination width are zero.
- R2: Operand `b` is read at the source width and brought to the destination width. When `sext_i` is 1 it is sign-extended, and when it is 0 it is zero-extended. A source wider than the destination is truncated. Bits of `a` above the destination width are ignored.
- R3: Add, add-with-carry (carry-in is the current CF) and subtract compute their result at the destination width. CF is the carry out of the destination width, and for subtract it is the borrow. OF is the signed overflow at the destination width.
- R4: The flag bus is ordered CF=bit 4, ZF=bit 3, SF=bit 2, OF=bit 1, PF=bit 0. ZF and SF use only the destination-width result. PF is 1 when the low byte of the result holds an even number of ones.
- R5: Add, add-with-carry, subtract and population count normally write flags. With `flag_ctl_i`=1 they write no flags: `flags_we_o` is 0 and `flags_o` equals the incoming flags.
- R6: NOT, move, compare-to-mask and compare-to-boolean normally write no flags. With `flag_ctl_i`=1 they write flags computed from their result compared with zero, with CF=0 and OF=0. Population count also produces flags this way.
- R7: With `pred_en_i`=1, the operation commits only if the condition `pred_cc_i` holds on the incoming flags. The condition codes are 0 O, 1 NO, 2 B, 3 AE, 4 E, 5 NE, 6 BE, 7 A, 8 S, 9 NS, 10 P, 11 NP, 12 L, 13 GE, 14 LE, 15 G. On a false predicate, both `res_we_o` and `flags_we_o` are 0 and `flags_o` equals the incoming flags.
- R8: Compare-to-mask evaluates `cmp_cc_i` on the flags of `a` minus `b`. It gives all ones at the destination width when the condition holds, and zero otherwise.
- R9: Compare-to-boolean evaluates `cmp_cc_i` in the same way and gives 1 or 0.
- R10: NOT gives the inverted widened `b`, move gives the widened `b`, and population count gives the number of ones in the widened `b`.
- R11: Outputs are registered with one cycle of latency. A synchronous active-high reset clears every output. With `op_valid_i`=0 nothing is written, and `flags_o` follows the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 3 | Operation code |
| src_sz_i | input | 2 | Source size code |
| dst_sz_i | input | 2 | Destination size code |
| sext_i | input | 1 | 1 = sign-extend source, 0 = zero-extend |
| flag_ctl_i | input | 1 | Invert the operation's flag-write behaviour |
| pred_en_i | input | 1 | Predicate the operation on pred_cc_i |
| pred_cc_i | input | 4 | Predicate condition code |
| cmp_cc_i | input | 4 | Condition used by the compare operations |
| a_i | input | XLEN | First source operand |
| b_i | input | XLEN | Second or only source operand |
| flags_i | input | 5 | Current flags {CF,ZF,SF,OF,PF} |
| res_o | output | XLEN | Result, zero above the destination width |
| res_we_o | output | 1 | Result write enable |
| flags_o | output | 5 | New flags, or the incoming flags when not written |
| flags_we_o | output | 1 | Flags write enable |

## Verification
Every result, enable and flag value is due at the first rising edge after the operation is presented. No output has a longer path. The bench drives each operation just after a falling edge and samples all four outputs 1 ns after the following rising edge. The value of `flags_o` on non-writing cycles is compared with the incoming flags of that same cycle. The checker properties use one-cycle implications for the same reason.

// File: rtl/xeu_pkg.sv
package xeu_pkg;

  localparam int FLAG_W = 5;
  localparam int F_CF   = 4;
  localparam int F_ZF   = 3;
  localparam int F_SF   = 2;
  localparam int F_OF   = 1;
  localparam int F_PF   = 0;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_SUB   = 3'd2,
    OP_NOT   = 3'd3,
    OP_MOV   = 3'd4,
    OP_POPC  = 3'd5,
    OP_CMASK = 3'd6,
    OP_CBOOL = 3'd7
  } xop_e;

  // Condition evaluation: bits [3:1] pick the test, bit 0 inverts it.
  function automatic logic cond_hit(input logic [FLAG_W-1:0] f, input logic [3:0] cc);
    logic t;
    case (cc[3:1])
      3'd0: t = f[F_OF];
      3'd1: t = f[F_CF];
      3'd2: t = f[F_ZF];
      3'd3: t = f[F_CF] | f[F_ZF];
      3'd4: t = f[F_SF];
      3'd5: t = f[F_PF];
      3'd6: t = f[F_SF] ^ f[F_OF];
      default: t = f[F_ZF] | (f[F_SF] ^ f[F_OF]);
    endcase
    return t ^ cc[0];
  endfunction

  function automatic logic writes_flags(input xop_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_POPC};
  endfunction

endpackage

// File: rtl/xeu_widen.sv
module xeu_widen #(
  parameter int XLEN = 64,
  parameter int SZW  = 2
) (
  input  logic [XLEN-1:0] val,
  input  logic [SZW-1:0]  src_sz,
  input  logic [SZW-1:0]  dst_sz,
  input  logic            sext,
  output logic [XLEN-1:0] ext,
  output logic [XLEN-1:0] dmask
);
  localparam int NSZ = 1 << SZW;

  logic [XLEN-1:0] tab [NSZ];
  logic [XLEN-1:0] smask;
  logic            sgn;

  for (genvar k = 0; k < NSZ; k++) begin : g_mask
    localparam int W = 8 << k;
    if (W >= XLEN) begin : g_full
      assign tab[k] = '1;
    end else begin : g_part
      assign tab[k] = (XLEN'(1) << W) - XLEN'(1);
    end
  end

  assign smask = tab[src_sz];
  assign dmask = tab[dst_sz];
  assign sgn   = |(val & smask & ~(smask >> 1));
  assign ext   = ((val & smask) | ((sext && sgn) ? ~smask : '0)) & dmask;

endmodule

// File: rtl/xeu_alu.sv
module xeu_alu import xeu_pkg::*; #(
  parameter int XLEN = 64
) (
  input  xop_e              op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic [XLEN-1:0]   dmask,
  input  logic              cin,
  input  logic [3:0]        cmp_cc,
  output logic [XLEN-1:0]   res,
  output logic [FLAG_W-1:0] flg
);
  logic [XLEN-1:0]   msb, bo, sres;
  logic [XLEN:0]     topb, sum;
  logic              sub_mode, ci, co, ovf, hit;
  logic [FLAG_W-1:0] fl_ar, fl_lg;

  assign msb  = dmask & ~(dmask >> 1);
  assign topb = {dmask, 1'b1} & ~{1'b0, dmask};

  always_comb begin
    sub_mode = op inside {OP_SUB, OP_CMASK, OP_CBOOL};
    bo       = sub_mode ? (~b & dmask) : b;
    ci       = sub_mode | ((op == OP_ADC) & cin);
    sum      = {1'b0, a} + {1'b0, bo} + {{XLEN{1'b0}}, ci};
    sres     = sum[XLEN-1:0] & dmask;
    co       = |(sum & topb);
    ovf      = ((|(a & msb)) == (|(bo & msb))) && ((|(sres & msb)) != (|(a & msb)));

    fl_ar        = '0;
    fl_ar[F_CF]  = sub_mode ? ~co : co;
    fl_ar[F_ZF]  = (sres == '0);
    fl_ar[F_SF]  = |(sres & msb);
    fl_ar[F_OF]  = ovf;
    fl_ar[F_PF]  = ~^sres[7:0];
    hit          = cond_hit(fl_ar, cmp_cc);

    case (op)
      OP_ADD, OP_ADC, OP_SUB: res = sres;
      OP_NOT:                 res = ~b & dmask;
      OP_MOV:                 res = b;
      OP_POPC:                res = XLEN'($countones(b));
      OP_CMASK:               res = hit ? dmask : '0;
      default:                res = {{(XLEN-1){1'b0}}, hit};
    endcase

    fl_lg        = '0;
    fl_lg[F_ZF]  = (res == '0);
    fl_lg[F_SF]  = |(res & msb);
    fl_lg[F_PF]  = ~^res[7:0];

    flg = (op inside {OP_ADD, OP_ADC, OP_SUB}) ? fl_ar : fl_lg;
  end

endmodule

// File: rtl/ext_int_exec.sv
module ext_int_exec import xeu_pkg::*; #(
  parameter int XLEN = 64,
  parameter int SZW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [SZW-1:0]    src_sz_i,
  input  logic [SZW-1:0]    dst_sz_i,
  input  logic              sext_i,
  input  logic              flag_ctl_i,
  input  logic              pred_en_i,
  input  logic [3:0]        pred_cc_i,
  input  logic [3:0]        cmp_cc_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [XLEN-1:0]   res_o,
  output logic              res_we_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              flags_we_o
);
  xop_e              op;
  logic [XLEN-1:0]   b_w, a_w, dmask, alu_res;
  logic [FLAG_W-1:0] alu_flg;
  logic              commit, want_flags;

  assign op = xop_e'(op_i);

  xeu_widen #(.XLEN(XLEN), .SZW(SZW)) u_widen (
    .val    (b_i),
    .src_sz (src_sz_i),
    .dst_sz (dst_sz_i),
    .sext   (sext_i),
    .ext    (b_w),
    .dmask  (dmask)
  );

  assign a_w = a_i & dmask;

  xeu_alu #(.XLEN(XLEN)) u_alu (
    .op     (op),
    .a      (a_w),
    .b      (b_w),
    .dmask  (dmask),
    .cin    (flags_i[F_CF]),
    .cmp_cc (cmp_cc_i),
    .res    (alu_res),
    .flg    (alu_flg)
  );

  assign commit     = op_valid_i && (!pred_en_i || cond_hit(flags_i, pred_cc_i));
  assign want_flags = writes_flags(op) ^ flag_ctl_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      res_we_o   <= 1'b0;
      flags_o    <= '0;
      flags_we_o <= 1'b0;
    end else begin
      res_o      <= alu_res;
      res_we_o   <= commit;
      flags_we_o <= commit && want_flags;
      flags_o    <= (commit && want_flags) ? alu_flg : flags_i;
    end
  end

endmodule

// File: rtl/xeu_chk.sv
module xeu_chk #(
  parameter int XLEN = 64,
  parameter int SZW  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid_i,
  input logic [2:0]      op_i,
  input logic [SZW-1:0]  dst_sz_i,
  input logic            flag_ctl_i,
  input logic            pred_en_i,
  input logic [3:0]      pred_cc_i,
  input logic [4:0]      flags_i,
  input logic [XLEN-1:0] res_o,
  input logic            res_we_o,
  input logic            flags_we_o
);
  // Independent condition check on {CF,ZF,SF,OF,PF}.
  function automatic logic holds(input logic [4:0] f, input logic [3:0] cc);
    logic cf, zf, sf, of, pf, t;
    {cf, zf, sf, of, pf} = f;
    unique case (cc)
      4'h0: t = of;            4'h1: t = !of;
      4'h2: t = cf;            4'h3: t = !cf;
      4'h4: t = zf;            4'h5: t = !zf;
      4'h6: t = cf || zf;      4'h7: t = !cf && !zf;
      4'h8: t = sf;            4'h9: t = !sf;
      4'hA: t = pf;            4'hB: t = !pf;
      4'hC: t = sf != of;      4'hD: t = sf == of;
      4'hE: t = zf || (sf != of);
      default: t = !zf && (sf == of);
    endcase
    return t;
  endfunction

  logic pred_false, flagger;
  assign pred_false = pred_en_i && !holds(flags_i, pred_cc_i);
  assign flagger    = (op_i == 3'd0) || (op_i == 3'd1) || (op_i == 3'd2) || (op_i == 3'd5);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && dst_sz_i == '0 |=> res_o[XLEN-1:8] == '0);

  p_suppress_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && flagger && flag_ctl_i |=> !flags_we_o);

  p_pred_false_r7: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && pred_false |=> !res_we_o && !flags_we_o);

  p_mask_shape_r8: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && op_i == 3'd6 && dst_sz_i == '1 |=> (res_o == '0 || &res_o));

  p_bool_shape_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && op_i == 3'd7 |=> res_o[XLEN-1:1] == '0);

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> !res_we_o && !flags_we_o);

  p_commit_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && !pred_en_i |=> res_we_o);

endmodule

bind ext_int_exec xeu_chk #(.XLEN(XLEN), .SZW(SZW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .dst_sz_i   (dst_sz_i),
  .flag_ctl_i (flag_ctl_i),
  .pred_en_i  (pred_en_i),
  .pred_cc_i  (pred_cc_i),
  .flags_i    (flags_i),
  .res_o      (res_o),
  .res_we_o   (res_we_o),
  .flags_we_o (flags_we_o)
);

// File: tb/tb_ext_int_exec.sv
module tb_ext_int_exec;
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ssz, dsz;
    logic        sx, fc, pe;
    logic [3:0]  pcc, ccc;
    logic [63:0] a, b;
    logic [4:0]  fin;
    logic [63:0] eres;
    logic        ewe;
    logic [4:0]  efl;
    logic        efwe;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  // flags {CF,ZF,SF,OF,PF}
  localparam vec_t VECS [NV] = '{
    '{3'd0,2'd0,2'd1,1'b1,1'b0,1'b0,4'h0,4'h0,64'h0100,ONES-64'h7F,5'b00000,64'h0080,1'b1,5'b10000,1'b1,8'd2},            // R2 sign-extended byte into word add
    '{3'd0,2'd0,2'd1,1'b0,1'b0,1'b0,4'h0,4'h0,64'h0100,ONES-64'h7F,5'b00000,64'h0180,1'b1,5'b00000,1'b1,8'd2},            // R2 zero extension
    '{3'd0,2'd0,2'd0,1'b0,1'b0,1'b0,4'h0,4'h0,64'hAB7F,64'h01,5'b00000,64'h80,1'b1,5'b00110,1'b1,8'd3},                   // R3 byte overflow
    '{3'd0,2'd3,2'd3,1'b0,1'b0,1'b0,4'h0,4'h0,ONES,64'h1,5'b00000,64'h0,1'b1,5'b11001,1'b1,8'd3},                         // R3 quad carry out
    '{3'd1,2'd1,2'd1,1'b0,1'b0,1'b0,4'h0,4'h0,64'h1234,64'h1,5'b10000,64'h1236,1'b1,5'b00001,1'b1,8'd3},                  // R3 add with carry
    '{3'd2,2'd2,2'd2,1'b0,1'b0,1'b0,4'h0,4'h0,64'h1,64'h2,5'b00000,64'hFFFF_FFFF,1'b1,5'b10101,1'b1,8'd3},                // R3 long borrow
    '{3'd2,2'd2,2'd2,1'b0,1'b1,1'b0,4'h0,4'h0,64'h1,64'h2,5'b01000,64'hFFFF_FFFF,1'b1,5'b01000,1'b0,8'd5},                // R5 suppressed flags
    '{3'd4,2'd0,2'd1,1'b1,1'b0,1'b0,4'h0,4'h0,64'h0,64'h85,5'b00001,64'hFF85,1'b1,5'b00001,1'b0,8'd10},                   // R10 move, no flags
    '{3'd4,2'd3,2'd3,1'b0,1'b1,1'b0,4'h0,4'h0,64'h0,64'h0,5'b10010,64'h0,1'b1,5'b01001,1'b1,8'd6},                        // R6 forced flags on move
    '{3'd3,2'd2,2'd2,1'b0,1'b0,1'b0,4'h0,4'h0,64'h0,64'hFFFF_FFFF_0F0F_0F0F,5'b00000,64'hF0F0_F0F0,1'b1,5'b00000,1'b0,8'd10}, // R10 NOT long
    '{3'd5,2'd0,2'd0,1'b0,1'b0,1'b0,4'h0,4'h0,64'h0,ONES-64'hF4,5'b00000,64'h3,1'b1,5'b00001,1'b1,8'd10},                 // R10 popcount byte
    '{3'd5,2'd3,2'd3,1'b0,1'b0,1'b0,4'h0,4'h0,64'h0,ONES,5'b00000,64'h40,1'b1,5'b00000,1'b1,8'd10},                       // R10 popcount quad
    '{3'd6,2'd1,2'd1,1'b0,1'b0,1'b0,4'h0,4'hC,64'hFFFF,64'h1,5'b00000,64'hFFFF,1'b1,5'b00000,1'b0,8'd8},                  // R8 mask, signed less
    '{3'd6,2'd1,2'd1,1'b0,1'b0,1'b0,4'h0,4'h2,64'hFFFF,64'h1,5'b00000,64'h0,1'b1,5'b00000,1'b0,8'd8},                     // R8 mask, unsigned below false
    '{3'd7,2'd3,2'd3,1'b0,1'b0,1'b0,4'h0,4'h4,64'h1234_5678_9ABC_DEF0,64'h1234_5678_9ABC_DEF0,5'b00000,64'h1,1'b1,5'b00000,1'b0,8'd9}, // R9 equal
    '{3'd7,2'd0,2'd0,1'b0,1'b0,1'b0,4'h0,4'hF,64'h05,64'h80,5'b00000,64'h1,1'b1,5'b00000,1'b0,8'd9},                      // R9 signed greater
    '{3'd0,2'd0,2'd0,1'b0,1'b0,1'b1,4'h1,4'h0,64'h1,64'h1,5'b00010,64'h0,1'b0,5'b00010,1'b0,8'd7},                        // R7 NO false
    '{3'd0,2'd0,2'd0,1'b0,1'b0,1'b1,4'h1,4'h0,64'h1,64'h1,5'b00000,64'h2,1'b1,5'b00000,1'b1,8'd7},                        // R7 NO true
    '{3'd2,2'd1,2'd1,1'b0,1'b0,1'b1,4'h7,4'h0,64'h5,64'h5,5'b00000,64'h0,1'b1,5'b01001,1'b1,8'd7},                        // R7 A true
    '{3'd4,2'd3,2'd3,1'b0,1'b1,1'b1,4'h4,4'h0,64'h0,64'h7,5'b10000,64'h0,1'b0,5'b10000,1'b0,8'd7},                        // R7 E false
    '{3'd4,2'd3,2'd0,1'b0,1'b0,1'b0,4'h0,4'h0,64'h0,64'h1FF,5'b00000,64'hFF,1'b1,5'b00000,1'b0,8'd2},                     // R2 truncating wider source
    '{3'd0,2'd1,2'd1,1'b0,1'b0,1'b0,4'h0,4'h0,64'hFFFF_8000,64'h0,5'b00000,64'h8000,1'b1,5'b00101,1'b1,8'd4}              // R4 sign and parity at word
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  src_sz_i = '0, dst_sz_i = '0;
  logic        sext_i = 1'b0, flag_ctl_i = 1'b0, pred_en_i = 1'b0;
  logic [3:0]  pred_cc_i = '0, cmp_cc_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [4:0]  flags_i = '0;
  logic [63:0] res_o;
  logic        res_we_o, flags_we_o;
  logic [4:0]  flags_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_int_exec dut (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
    .src_sz_i(src_sz_i), .dst_sz_i(dst_sz_i), .sext_i(sext_i),
    .flag_ctl_i(flag_ctl_i), .pred_en_i(pred_en_i), .pred_cc_i(pred_cc_i),
    .cmp_cc_i(cmp_cc_i), .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
    .res_o(res_o), .res_we_o(res_we_o), .flags_o(flags_o), .flags_we_o(flags_we_o)
  );

  task automatic chk(input bit ok, input int r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    op_valid_i = 1'b1; op_i = v.op; src_sz_i = v.ssz; dst_sz_i = v.dsz;
    sext_i = v.sx; flag_ctl_i = v.fc; pred_en_i = v.pe; pred_cc_i = v.pcc;
    cmp_cc_i = v.ccc; a_i = v.a; b_i = v.b; flags_i = v.fin;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R11 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset holds every output at zero even with a valid operation present
    drive(VECS[0]);
    chk(res_o == 64'h0 && !res_we_o && !flags_we_o && flags_o == 5'b0, 11,
        "reset state", {res_o[60:0], res_we_o, flags_we_o, 1'b0}, 64'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk(res_we_o == VECS[i].ewe, int'(VECS[i].req), $sformatf("vec %0d res_we", i),
          64'(res_we_o), 64'(VECS[i].ewe));
      chk(flags_we_o == VECS[i].efwe, int'(VECS[i].req), $sformatf("vec %0d flags_we", i),
          64'(flags_we_o), 64'(VECS[i].efwe));
      chk(flags_o == VECS[i].efl, int'(VECS[i].req), $sformatf("vec %0d flags", i),
          64'(flags_o), 64'(VECS[i].efl));
      if (VECS[i].ewe)
        chk(res_o == VECS[i].eres, int'(VECS[i].req), $sformatf("vec %0d result", i),
            res_o, VECS[i].eres);
    end

    // R11: idle cycle writes nothing and flags pass through
    drive(VECS[3]);
    @(negedge clk);
    op_valid_i = 1'b0; flags_i = 5'b10110;
    @(posedge clk); #1;
    chk(!res_we_o && !flags_we_o, 11, "idle enables", {62'b0, res_we_o, flags_we_o}, 64'h0);
    chk(flags_o == 5'b10110, 11, "idle flags pass", 64'(flags_o), 64'h16);

    // R1: quad compare-to-mask true gives all ones; byte add keeps upper bits zero
    drive('{3'd6,2'd3,2'd3,1'b0,1'b0,1'b0,4'h0,4'h3,64'h9,64'h2,5'b00000,64'h0,1'b0,5'b0,1'b0,8'd1});
    chk(res_o == ONES, 1, "quad mask all ones", res_o, ONES);
    drive('{3'd0,2'd3,2'd0,1'b1,1'b0,1'b0,4'h0,4'h0,ONES,ONES,5'b00000,64'h0,1'b0,5'b0,1'b0,8'd1});
    chk(res_o == 64'hFE, 1, "byte add upper zero", res_o, 64'hFE);

    // R11: reset mid-stream clears outputs
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk(res_o == 64'h0 && !res_we_o && flags_o == 5'b0, 11, "re-reset", res_o, 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule